// File: doc/BRIEF.md
# Table-Driven Fixed-Coefficient Multiplier

This block multiplies an unsigned 8-bit operand by a coefficient that is fixed when the design is built. No AND-gate array and no chain of adders are used. The operand is cut into 4-bit digits. Each digit selects one of 16 precomputed multiples of the coefficient from a small table. The table contents are derived from the coefficient parameter at elaboration, so no memory file is needed. The partial results are placed at their digit positions and summed once to give the full 16-bit product.

An optional input register, chosen by a parameter, captures the operand on each rising clock edge. With the register present, the product appears one cycle after the operand is sampled. Without it, the path is purely combinational. The coefficient cannot change at run time.

Top module: `tbl_coef_mult`

## Requirements
- R1: With `IN_REG`=1, `product_o` equals `operand_i` × `COEF` for the operand sampled at the most recent rising edge of `clk`.
- R2: With `IN_REG`=1, changes on `operand_i` between two rising edges do not alter `product_o` until the next edge.
- R3: With `IN_REG`=1, while `rst_n` is low (asynchronous, active low) the captured operand is zero, so `product_o` is 0.
- R4: The extremes are exact: operand 0 gives 0, and operand 255 gives 255×`COEF`, which fits in 16 bits for any 8-bit coefficient.
- R5: The low digit (operand bits 3:0) contributes its multiple at weight 1, and the high digit (bits 7:4) contributes at weight 16. So 0x0F gives 15×`COEF` and 0xF0 gives 240×`COEF`.
- R6: The parameter `COEF` alone selects the constant (default 8'b10101011 = 171). Instances built with different coefficients each give the correct product over all 256 operands.
- R7: With `IN_REG`=0, `product_o` equals `operand_i` × `COEF` in the same cycle, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional operand register |
| rst_n | input | 1 | Asynchronous active-low reset of the operand register |
| operand_i | input | 8 | Unsigned variable operand |
| product_o | output | 16 | Unsigned product operand × COEF |

## Verification
The two digit lookups and their weighted sum all act on the same operand in the same cycle. The high digit's table output and the low digit's table output therefore meet in one addition. Operands with both digits nonzero, such as 0xFF and random values, provoke the overlap of shifted partials where carries cross bit 4 through bit 11. Sweeping every operand on several coefficients, including 255 and 1, judges each sum against a product that the bench computes itself. A second overlap occurs between operand capture and an operand change within the same cycle: the bench changes the input after the edge and checks that the output still shows the captured value.

// File: rtl/tbl_coef_pkg.sv
package tbl_coef_pkg;
    // Multiple of a coefficient by a small digit, used to fill the tables.
    function automatic logic [31:0] coef_multiple(input logic [31:0] coef,
                                                  input int unsigned digit);
        return coef * digit;
    endfunction
endpackage

// File: rtl/tbl_coef_in_stage.sv
module tbl_coef_in_stage #(
    parameter int W      = 8,
    parameter bit IN_REG = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    generate
        if (IN_REG) begin : g_reg
            logic [W-1:0] hold_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) hold_q <= '0;
                else        hold_q <= d_i;
            end
            assign q_o = hold_q;
        end else begin : g_thru
            assign q_o = d_i;
        end
    endgenerate
endmodule

// File: rtl/tbl_coef_digit_lut.sv
module tbl_coef_digit_lut
    import tbl_coef_pkg::*;
#(
    parameter int              COEF_W  = 8,
    parameter int              DIGIT_W = 4,
    parameter logic [COEF_W-1:0] COEF  = 8'b10101011,
    localparam int             ENTRIES = 1 << DIGIT_W,
    localparam int             PART_W  = COEF_W + DIGIT_W
) (
    input  logic [DIGIT_W-1:0] digit_i,
    output logic [PART_W-1:0]  part_o
);
    logic [PART_W-1:0] table_q [ENTRIES];

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
            localparam logic [31:0] FULL = coef_multiple(32'(COEF), e);
            assign table_q[e] = FULL[PART_W-1:0];
        end
    endgenerate

    assign part_o = table_q[digit_i];
endmodule

// File: rtl/tbl_coef_shift_sum.sv
module tbl_coef_shift_sum #(
    parameter int NUM_DIG = 2,
    parameter int DIGIT_W = 4,
    parameter int PART_W  = 12,
    parameter int PROD_W  = 16
) (
    input  logic [NUM_DIG-1:0][PART_W-1:0] parts_i,
    output logic [PROD_W-1:0]              sum_o
);
    always_comb begin
        sum_o = '0;
        for (int d = 0; d < NUM_DIG; d++) begin
            sum_o = sum_o + (PROD_W'(parts_i[d]) << (d * DIGIT_W));
        end
    end
endmodule

// File: rtl/tbl_coef_mult.sv
module tbl_coef_mult #(
    parameter int                IN_W    = 8,
    parameter int                COEF_W  = 8,
    parameter int                DIGIT_W = 4,
    parameter logic [COEF_W-1:0] COEF    = 8'b10101011,
    parameter bit                IN_REG  = 1'b1,
    localparam int               NUM_DIG = IN_W / DIGIT_W,
    localparam int               PART_W  = COEF_W + DIGIT_W,
    localparam int               PROD_W  = IN_W + COEF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IN_W-1:0]   operand_i,
    output logic [PROD_W-1:0] product_o
);
    logic [IN_W-1:0]                 op_q;
    logic [NUM_DIG-1:0][PART_W-1:0]  parts;

    tbl_coef_in_stage #(.W(IN_W), .IN_REG(IN_REG)) u_in (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (operand_i),
        .q_o   (op_q)
    );

    generate
        for (genvar d = 0; d < NUM_DIG; d++) begin : g_digit
            tbl_coef_digit_lut #(
                .COEF_W (COEF_W),
                .DIGIT_W(DIGIT_W),
                .COEF   (COEF)
            ) u_lut (
                .digit_i(op_q[d*DIGIT_W +: DIGIT_W]),
                .part_o (parts[d])
            );
        end
    endgenerate

    tbl_coef_shift_sum #(
        .NUM_DIG(NUM_DIG),
        .DIGIT_W(DIGIT_W),
        .PART_W (PART_W),
        .PROD_W (PROD_W)
    ) u_sum (
        .parts_i(parts),
        .sum_o  (product_o)
    );
endmodule

// File: rtl/tbl_coef_mult_chk.sv
module tbl_coef_mult_chk #(
    parameter int                IN_W   = 8,
    parameter int                COEF_W = 8,
    parameter logic [COEF_W-1:0] COEF   = 8'b10101011,
    parameter bit                IN_REG = 1'b1,
    localparam int               PROD_W = IN_W + COEF_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IN_W-1:0]   operand_i,
    input logic [PROD_W-1:0] product_o
);
    localparam logic [PROD_W-1:0] C_EXT = PROD_W'(COEF);
    localparam logic [PROD_W-1:0] P_MAX = PROD_W'((1 << IN_W) - 1) * C_EXT;

    // R1 / R2: registered product tracks the previously sampled operand
    a_r1_registered_product: assert property (@(posedge clk) disable iff (!rst_n)
        (IN_REG && $past(rst_n)) |-> (product_o == PROD_W'($past(operand_i)) * C_EXT));

    // R3: reset clears the captured operand
    a_r3_reset_zero: assert property (@(posedge clk)
        (IN_REG && !rst_n && $past(!rst_n)) |-> (product_o == '0));

    // R4: the product never exceeds the largest possible value
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        product_o <= P_MAX);

    // R4: a zero operand yields zero
    a_r4_zero_in_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
        (IN_REG && $past(rst_n) && $past(operand_i) == '0) |-> (product_o == '0));

    // R7: combinational variant follows the operand directly
    a_r7_comb_product: assert property (@(posedge clk) disable iff (!rst_n)
        !IN_REG |-> (product_o == PROD_W'(operand_i) * C_EXT));
endmodule

bind tbl_coef_mult tbl_coef_mult_chk #(
    .IN_W  (IN_W),
    .COEF_W(COEF_W),
    .COEF  (COEF),
    .IN_REG(IN_REG)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .operand_i(operand_i),
    .product_o(product_o)
);

// File: tb/tbl_coef_mult_tb.sv
module tbl_coef_mult_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] op = 8'h00;
    logic [15:0] p_dut, p_255, p_one, p_comb;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tbl_coef_mult #(.COEF(8'b10101011), .IN_REG(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .operand_i(op), .product_o(p_dut));
    tbl_coef_mult #(.COEF(8'd255), .IN_REG(1'b1)) u_dut_c255 (
        .clk(clk), .rst_n(rst_n), .operand_i(op), .product_o(p_255));
    tbl_coef_mult #(.COEF(8'd1), .IN_REG(1'b1)) u_dut_c1 (
        .clk(clk), .rst_n(rst_n), .operand_i(op), .product_o(p_one));
    tbl_coef_mult #(.COEF(8'd90), .IN_REG(1'b0)) u_dut_comb (
        .clk(clk), .rst_n(rst_n), .operand_i(op), .product_o(p_comb));

    function automatic logic [15:0] ref_mul(input logic [7:0] n, input logic [7:0] c);
        return 16'(n) * 16'(c);
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, let the next rising edge capture, check at the next falling edge.
    task automatic apply_and_check(input logic [7:0] v, input string tag);
        @(negedge clk);
        op = v;
        #1;
        chk(p_comb, ref_mul(v, 8'd90), "R7 comb");
        @(negedge clk);
        chk(p_dut, ref_mul(v, 8'd171), tag);
        chk(p_255, ref_mul(v, 8'd255), "R6 coef255");
        chk(p_one, ref_mul(v, 8'd1),   "R6 coef1");
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d2c));
        // R3: reset holds the product at zero even with a nonzero operand
        op = 8'hFF;
        repeat (3) @(negedge clk);
        chk(p_dut, 16'd0, "R3 reset");
        chk(p_255, 16'd0, "R3 reset c255");
        @(negedge clk);
        rst_n = 1'b1;

        // R4 / R5 directed corners
        apply_and_check(8'h00, "R4 zero");
        apply_and_check(8'hFF, "R4 max");
        apply_and_check(8'h0F, "R5 low digit");
        apply_and_check(8'hF0, "R5 high digit");
        apply_and_check(8'h10, "R5 high weight");
        apply_and_check(8'h01, "R5 low weight");

        // R1 / R6: every operand
        for (int v = 0; v < 256; v++) apply_and_check(8'(v), "R1 sweep");

        // R1: random operands
        for (int i = 0; i < 200; i++) apply_and_check(8'($urandom), "R1 random");

        // R2: a change after the capturing edge does not reach the output
        for (int i = 0; i < 8; i++) begin
            logic [7:0] v;
            v = 8'($urandom);
            @(negedge clk);
            op = v;
            @(posedge clk);
            #2;
            op = ~v;
            #2;
            chk(p_dut, ref_mul(v, 8'd171), "R2 hold");
            @(negedge clk);
            chk(p_dut, ref_mul(v, 8'd171), "R2 hold late");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule